// File: doc/BRIEF.md
# Multi-Lane Vector Element Sequencer

This block is a small vector execution unit. It takes one vector instruction at a time through a valid/ready handshake, with the element count given at acceptance. It then sends the elements through a fixed pipeline of five stages: an operand-read stage, three execute stages and a write-back stage. The elements are spread over `LANES` parallel lanes. Element `i` goes to lane `i mod LANES`, so issue cycle `g` carries elements `g*LANES` up to `g*LANES+LANES-1`. The groups of one instruction issue on consecutive cycles with no bubble between them. Between the last group of one instruction and the first group of the next, the sequencer always holds a fixed gap of `DEAD_CYCLES` cycles in which nothing is issued.

The controller is a three-state machine. `ST_IDLE` waits for an instruction with ready high. The transition *accept* goes to `ST_ISSUE`, which issues one group per cycle. The transition *last group* goes to `ST_GAP`, which counts down the dead cycles. Ready rises again only in the final gap cycle. From there the transition *chain* goes straight back to `ST_ISSUE` if an instruction is offered, and the transition *drain* goes to `ST_IDLE` if none is. A short final group masks its unused lanes as invalid.

The write-back stage raises a strobe for each lane together with the element index, and pulses `done` with the last group. Two free-running counters record elapsed cycles and issuing cycles. The ratio of the two, for back-to-back instructions of `G` groups each, is `G/(G+DEAD_CYCLES)`. `LANES` must be a power of two that divides `MAX_LEN`, and `in_len` must lie between 1 and `MAX_LEN`.

Top module: `vls_lane_seq`

## Requirements
- R1: During and after a synchronous active-high reset, `in_ready`=1, `busy`=0, `wb_valid`=0, `done`=0, and both counters read 0.
- R2: An instruction accepted at a clock edge issues group 0 in the next cycle and one further group in each following cycle, with no gap. Group `g` places element `g*LANES+l` in lane `l`.
- R3: Exactly `DEAD_CYCLES` (4) cycles without issue separate the last group of one instruction from the first group of the next when the next one is already offered. `in_ready` is 0 during issue and during all but the last gap cycle, and 1 in the last gap cycle and in idle.
- R4: A lane that issues in cycle `k` raises its bit of `wb_valid` in cycle `k+4`, after 1 read, 3 execute and 1 write cycle. Its `wb_idx` field (bits `l*IDX_W +: IDX_W`) holds the element index.
- R5: In a final group where `in_len` is not a multiple of `LANES`, lanes with element index `>= in_len` stay invalid. `wb_valid` is therefore always a contiguous run of ones from bit 0.
- R6: `done` is high for exactly one cycle, in the write-back cycle of an instruction's last group.
- R7: `cyc_total` increments by one on every clock edge after reset.
- R8: `cyc_issue` increments exactly on the edges that end a cycle in which at least one lane issued. For back-to-back instructions of `G` groups, it advances by `G` per `G+4` cycles.
- R9: `busy` is 1 from the cycle after acceptance through the last gap cycle, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_len | input | LEN_W | Element count, 1 to MAX_LEN |
| wb_valid | output | LANES | Per-lane write-back strobe |
| wb_idx | output | LANES*IDX_W | Per-lane element index at write-back |
| done | output | 1 | Last group of an instruction writes back |
| busy | output | 1 | Issuing or in the dead-cycle gap |
| cyc_total | output | CNT_W | Cycles since reset |
| cyc_issue | output | CNT_W | Cycles in which any lane issued |

## Verification
When instructions are offered back to back, the `done` pulse of one instruction lands in the same cycle as the acceptance of the next. Both happen in the last gap cycle, exactly `G+4` cycles after the earlier acceptance. The bench provokes this collision by holding `in_valid` high through a sweep of every length from 1 to 128. It computes the expected write-back mask, indices, `done`, `busy` and `in_ready` for every cycle from the acceptance cycles. It also checks that the two events coincide and that the counter deltas between consecutive acceptances equal `G+4` and `G`.

// File: rtl/vls_pkg.sv
package vls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_LEN     = 128,
    parameter int DEAD_CYCLES = 4,
    parameter int LEN_W       = 8,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LEN_W-1:0] in_len,
    output logic             in_ready,
    output logic [LANES-1:0] issue_mask,
    output logic [IDX_W-1:0] issue_base,
    output logic             issue_last,
    output logic             busy
);
    localparam int GAP_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] base_q;
    logic [GAP_W-1:0] gap_q;
    logic             accept;
    logic             grp_last;
    logic             gap_end;

    // element index one past the current group
    assign grp_last = (LEN_W'(base_q) + LEN_W'(LANES)) >= len_q;
    assign gap_end  = (gap_q == '0);
    assign accept   = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state: accept, last group, chain, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_d = ST_ISSUE;
            ST_ISSUE: if (grp_last) state_d = ST_GAP;
            ST_GAP:   if (gap_end)  state_d = accept ? ST_ISSUE : ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // instruction length, group base and gap down-counter
    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            base_q <= '0;
            gap_q  <= '0;
        end else begin
            if (accept) begin
                len_q  <= in_len;
                base_q <= '0;
            end else if (state_q == ST_ISSUE) begin
                base_q <= base_q + IDX_W'(LANES);
            end
            if (state_q == ST_ISSUE && grp_last) gap_q <= GAP_W'(DEAD_CYCLES - 1);
            else if (state_q == ST_GAP && !gap_end) gap_q <= gap_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready   = (state_q == ST_IDLE) || (state_q == ST_GAP && gap_end);
        busy       = (state_q != ST_IDLE);
        issue_base = base_q;
        issue_last = (state_q == ST_ISSUE) && grp_last;
        for (int l = 0; l < LANES; l++) begin
            issue_mask[l] = (state_q == ST_ISSUE) &&
                            ((LEN_W'(base_q) + LEN_W'(l)) < len_q);
        end
    end
endmodule

// File: rtl/vls_stage_pipe.sv
module vls_stage_pipe #(
    parameter int DEPTH = 4,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    logic         vld_q  [DEPTH];
    logic [W-1:0] data_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[s]  <= 1'b0;
                    data_q[s] <= '0;
                end else begin
                    vld_q[s]  <= in_vld;
                    data_q[s] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[s]  <= 1'b0;
                    data_q[s] <= '0;
                end else begin
                    vld_q[s]  <= vld_q[s-1];
                    data_q[s] <= data_q[s-1];
                end
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_data = data_q[DEPTH-1];
endmodule

// File: rtl/vls_cycle_cnt.sv
module vls_cycle_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_any,
    output logic [CNT_W-1:0] cyc_total,
    output logic [CNT_W-1:0] cyc_issue
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_total <= '0;
            cyc_issue <= '0;
        end else begin
            cyc_total <= cyc_total + 1'b1;
            if (issue_any) cyc_issue <= cyc_issue + 1'b1;
        end
    end
endmodule

// File: rtl/vls_lane_seq.sv
module vls_lane_seq #(
    parameter int LANES       = 4,
    parameter int MAX_LEN     = 128,
    parameter int EXEC_STAGES = 3,
    parameter int DEAD_CYCLES = 4,
    parameter int CNT_W       = 32,
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int IDX_W      = $clog2(MAX_LEN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LEN_W-1:0]       in_len,
    output logic [LANES-1:0]       wb_valid,
    output logic [LANES*IDX_W-1:0] wb_idx,
    output logic                   done,
    output logic                   busy,
    output logic [CNT_W-1:0]       cyc_total,
    output logic [CNT_W-1:0]       cyc_issue
);
    // the issue cycle is the read stage; execute plus write stages are registered
    localparam int PIPE_DEPTH = EXEC_STAGES + 1;

    logic [LANES-1:0] issue_mask;
    logic [IDX_W-1:0] issue_base;
    logic             issue_last;
    logic             issue_any;
    logic             last_wb;

    assign issue_any = |issue_mask;

    vls_ctrl #(
        .LANES      (LANES),
        .MAX_LEN    (MAX_LEN),
        .DEAD_CYCLES(DEAD_CYCLES),
        .LEN_W      (LEN_W),
        .IDX_W      (IDX_W)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_len    (in_len),
        .in_ready  (in_ready),
        .issue_mask(issue_mask),
        .issue_base(issue_base),
        .issue_last(issue_last),
        .busy      (busy)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_lead
            // lane 0 is valid in every group, so it also carries the last flag
            vls_stage_pipe #(.DEPTH(PIPE_DEPTH), .W(IDX_W + 1)) i_pipe (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (issue_mask[l]),
                .in_data ({issue_last, issue_base}),
                .out_vld (wb_valid[l]),
                .out_data({last_wb, wb_idx[l*IDX_W +: IDX_W]})
            );
        end else begin : g_follow
            vls_stage_pipe #(.DEPTH(PIPE_DEPTH), .W(IDX_W)) i_pipe (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (issue_mask[l]),
                .in_data (issue_base + IDX_W'(l)),
                .out_vld (wb_valid[l]),
                .out_data(wb_idx[l*IDX_W +: IDX_W])
            );
        end
    end

    assign done = wb_valid[0] && last_wb;

    vls_cycle_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .issue_any(issue_any),
        .cyc_total(cyc_total),
        .cyc_issue(cyc_issue)
    );
endmodule

// File: rtl/vls_lane_seq_chk.sv
module vls_lane_seq_chk #(
    parameter int LANES       = 4,
    parameter int EXEC_STAGES = 3,
    parameter int DEAD_CYCLES = 4,
    parameter int CNT_W       = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             issue_any,
    input logic [LANES-1:0] wb_valid,
    input logic             done,
    input logic             busy,
    input logic [CNT_W-1:0] cyc_total,
    input logic [CNT_W-1:0] cyc_issue
);
    localparam int D      = EXEC_STAGES + 1;
    localparam int IDLE_W = $clog2(DEAD_CYCLES + 1);

    logic [D-1:0]      hist_q;
    logic [IDLE_W-1:0] idle_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            idle_q <= '0;
            seen_q <= 1'b0;
        end else begin
            hist_q <= D'({hist_q, issue_any});
            if (issue_any) begin
                idle_q <= '0;
                seen_q <= 1'b1;
            end else if (idle_q != IDLE_W'(DEAD_CYCLES)) begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    p_issue_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> issue_any);
    p_no_ready_while_issuing_r3: assert property (@(posedge clk) disable iff (rst)
        issue_any |-> !in_ready);
    p_dead_gap_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(issue_any) && seen_q) |-> (idle_q == IDLE_W'(DEAD_CYCLES)));
    p_wb_after_issue_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid != '0) |-> hist_q[D-1]);
    p_mask_prefix_r5: assert property (@(posedge clk) disable iff (rst)
        ((wb_valid + LANES'(1)) & wb_valid) == '0);
    p_done_on_wb_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> wb_valid[0]);
    p_total_step_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cyc_total == $past(cyc_total) + 1'b1));
    p_issue_step_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cyc_issue == $past(cyc_issue) + CNT_W'($past(issue_any))));
    p_busy_issue_r9: assert property (@(posedge clk) disable iff (rst)
        issue_any |-> busy);
endmodule

bind vls_lane_seq vls_lane_seq_chk #(
    .LANES      (LANES),
    .EXEC_STAGES(EXEC_STAGES),
    .DEAD_CYCLES(DEAD_CYCLES),
    .CNT_W      (CNT_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .issue_any(issue_any),
    .wb_valid (wb_valid),
    .done     (done),
    .busy     (busy),
    .cyc_total(cyc_total),
    .cyc_issue(cyc_issue)
);

// File: tb/test_vls_lane_seq.sv
module test_vls_lane_seq;
    localparam int LANES = 4;
    localparam int MAXL  = 128;
    localparam int DEAD  = 4;
    localparam int CW    = 32;
    localparam int LEN_W = $clog2(MAXL + 1);
    localparam int IDX_W = $clog2(MAXL);
    localparam int EXP_N = 8192;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [LEN_W-1:0]       in_len = '0;
    logic [LANES-1:0]       wb_valid;
    logic [LANES*IDX_W-1:0] wb_idx;
    logic                   done;
    logic                   busy;
    logic [CW-1:0]          cyc_total;
    logic [CW-1:0]          cyc_issue;

    vls_lane_seq #(.LANES(LANES), .MAX_LEN(MAXL), .DEAD_CYCLES(DEAD), .CNT_W(CW)) i_vls_lane_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .done(done), .busy(busy),
        .cyc_total(cyc_total), .cyc_issue(cyc_issue)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0, n_fail = 0, tick = 0, total_groups = 0;
    int prev_acc = -1, prev_g = 0, prev_issue = 0;
    bit valid_gap = 1'b1, ended = 1'b0;
    logic [LANES-1:0] exp_mask [EXP_N];
    int  exp_base [EXP_N];
    bit  exp_part [EXP_N], exp_done [EXP_N], exp_busy [EXP_N], exp_rdy [EXP_N];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, tick, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) if (!rst) tick <= tick + 1;

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (!rst && !ended && tick < EXP_N - 200) begin
            automatic int t = tick;
            chk(wb_valid == exp_mask[t], exp_part[t] ? "R5" : "R2", "wb_valid", int'(wb_valid), int'(exp_mask[t]));
            for (int l = 0; l < LANES; l++)
                if (exp_mask[t][l])
                    chk(int'(wb_idx[l*IDX_W +: IDX_W]) == exp_base[t] + l, "R4", "wb_idx",
                        int'(wb_idx[l*IDX_W +: IDX_W]), exp_base[t] + l);
            chk(done == exp_done[t], "R6", "done", int'(done), int'(exp_done[t]));
            chk(busy == exp_busy[t], "R9", "busy", int'(busy), int'(exp_busy[t]));
            chk(in_ready == exp_rdy[t], "R3", "in_ready", int'(in_ready), int'(exp_rdy[t]));
            chk(int'(cyc_total) == t, "R7", "cyc_total", int'(cyc_total), t);
            if (!in_valid) valid_gap = 1'b1;
            if (in_valid && in_ready) begin
                automatic int len = int'(in_len);
                automatic int g_n = (len + LANES - 1) / LANES;
                if (prev_acc >= 0 && !valid_gap) begin
                    chk(t - prev_acc == prev_g + DEAD, "R3", "accept spacing", t - prev_acc, prev_g + DEAD);
                    chk(int'(cyc_issue) - prev_issue == prev_g, "R8", "issue delta",
                        int'(cyc_issue) - prev_issue, prev_g);
                    chk(done == 1'b1, "R6", "done with next accept", int'(done), 1);
                end
                for (int g = 0; g < g_n; g++) begin
                    for (int l = 0; l < LANES; l++)
                        exp_mask[t + 5 + g][l] = (g * LANES + l < len);
                    exp_base[t + 5 + g] = g * LANES;
                    exp_part[t + 5 + g] = (g * LANES + LANES > len);
                end
                exp_done[t + 4 + g_n] = 1'b1;
                for (int k = 1; k <= g_n + DEAD; k++) exp_busy[t + k] = 1'b1;
                for (int k = 1; k < g_n + DEAD; k++) exp_rdy[t + k] = 1'b0;
                total_groups += g_n;
                prev_acc = t; prev_g = g_n; prev_issue = int'(cyc_issue);
                valid_gap = 1'b0;
            end
        end
    end

    task automatic send(input int len);
        in_len   = LEN_W'(len);
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic pause(input int n);
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < EXP_N; i++) begin
            exp_mask[i] = '0; exp_base[i] = 0; exp_part[i] = 1'b0;
            exp_done[i] = 1'b0; exp_busy[i] = 1'b0; exp_rdy[i] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(wb_valid == '0 && done == 1'b0, "R1", "reset wb/done", int'(wb_valid), 0);
        chk(cyc_total == '0 && cyc_issue == '0, "R1", "reset counters", int'(cyc_total), 0);
        rst = 1'b0;
        pause(3);
        send(5);                      // from idle, partial group
        pause(20);
        for (int len = 1; len <= MAXL; len++) send(len);   // back-to-back sweep
        pause(15);
        send(128); send(128); send(128);                   // peak utilisation
        send(1); send(128); send(3);
        pause(20);
        @(negedge clk);
        chk(int'(cyc_issue) == total_groups, "R8", "issue total", int'(cyc_issue), total_groups);
        chk(in_ready == 1'b1 && busy == 1'b0, "R9", "idle after drain", int'(busy), 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual 0 expected 1 (run completion)");
        finish_run();
    end
endmodule